// File: doc/BRIEF.md
# Parallel Flash Byte Program Controller

This block sits on the host side of an 8-bit asynchronous parallel flash device and programs one byte per request. A single-cycle `start` latches a target address and data byte. The controller then drives the unlock-and-program command sequence as four separate write strobes. After that it polls the device with read cycles until the internal program operation has settled or has failed.

Status is taken from three bits of each polled byte. Bit 6 toggles on every read while the device is busy. Bit 7 reads as the complement of the written bit 7 until the operation completes. Bit 5 rises when the device has run past its own time limit. A cycle counter also bounds the whole polling phase. Whenever the controller gives up, it writes the reset command before it reports. The outcome is a one-cycle `done` pulse or a one-cycle `error` pulse.

Strobe widths and the polling limit are parameters. Each bus phase is separated from the next by a cycle in which every strobe is released.

Top module: `flash_prog_ctrl`

## Requirements
- R1: A request produces exactly four write strobes, in this order: (UNLK1_ADDR, AAh), (UNLK2_ADDR, 55h), (UNLK1_ADDR, A0h), (request address, request data). The defaults are UNLK1_ADDR=555h and UNLK2_ADDR=2AAh.
- R2: While `fl_we_n` is low, `fl_addr` and `fl_dq_out` stay constant and `fl_dq_oe` and chip enable are asserted. Chip enable is already low in the cycle before `fl_we_n` falls.
- R3: `fl_oe_n` and `fl_we_n` are never low together. Every read strobe is preceded by a cycle with chip enable high, and `fl_dq_oe` is low whenever `fl_oe_n` is low.
- R4: Once two consecutive polled reads agree in bit 6, and bits 7:6 of the later read equal bits 7:6 of the request data, the controller reports `done`.
- R5: While bit 6 differs between consecutive reads and bit 5 is 0, the controller keeps issuing reads.
- R6: A read in which bit 6 differs from the previous read and bit 5 is 1 triggers exactly two further reads. If those two differ in bit 6, the controller writes F0h to UNLK1_ADDR and then reports `error`.
- R7: If the two further reads of R6 agree in bit 6, the controller reports `done` and issues no reset write.
- R8: Once POLL_LIMIT cycles of polling have passed, the next completed read ends polling. The controller then writes F0h to UNLK1_ADDR and reports `error`.
- R9: `done` and `error` are each high for exactly one cycle per request, and are never high together.
- R10: A `start` that arrives while a request is in progress has no effect: no further strobes appear and no extra result is reported.
- R11: During and after reset, all strobes are high, `fl_dq_oe` is low, and `done` and `error` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted only while idle |
| req_addr | input | AW | Target byte address |
| req_data | input | 8 | Byte to program |
| done | output | 1 | One-cycle success pulse |
| error | output | 1 | One-cycle failure pulse |
| fl_addr | output | AW | Flash address bus |
| fl_dq_out | output | 8 | Data driven to the flash |
| fl_dq_oe | output | 1 | Enables the host data driver |
| fl_dq_in | input | 8 | Data read from the flash |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |

## Verification
A behavioural flash model answers the polls in four patterns. In the first, the toggle stops after a set number of reads, which exercises plain completion (R4, R5). In the second, bit 5 appears and the toggle continues, which must end in the reset write and `error` (R6). In the third, bit 5 appears on the last busy read and the device then settles, which must still succeed (R7). In the fourth, the device toggles without end, so only the polling limit can end the request (R8). Data bytes with different bit-7/bit-6 combinations separate a correct data comparison from one that only looks at the toggle. A second `start` during a request shows whether the idle gate holds (R10).

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_WR,
        PH_RD,
        PH_GAP
    } phase_e;

    typedef enum logic [1:0] {
        NX_WR,
        NX_RD,
        NX_END
    } next_e;

    localparam logic [7:0] CMD_KEY_A = 8'hAA;
    localparam logic [7:0] CMD_KEY_B = 8'h55;
    localparam logic [7:0] CMD_PROG  = 8'hA0;
    localparam logic [7:0] CMD_RESET = 8'hF0;

    localparam logic [2:0] STEP_DATA  = 3'd3;
    localparam logic [2:0] STEP_RESET = 3'd4;

endpackage

// File: rtl/fp_cmd_sel.sv
module fp_cmd_sel
    import flash_prog_pkg::*;
#(
    parameter int AW = 16,
    parameter logic [AW-1:0] UNLK1_ADDR = 'h555,
    parameter logic [AW-1:0] UNLK2_ADDR = 'h2AA
) (
    input  logic [2:0]    step,
    input  logic [AW-1:0] tgt_addr,
    input  logic [7:0]    tgt_data,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data
);
    always_comb begin
        case (step)
            3'd0: begin wr_addr = UNLK1_ADDR; wr_data = CMD_KEY_A; end
            3'd1: begin wr_addr = UNLK2_ADDR; wr_data = CMD_KEY_B; end
            3'd2: begin wr_addr = UNLK1_ADDR; wr_data = CMD_PROG;  end
            3'd3: begin wr_addr = tgt_addr;   wr_data = tgt_data;  end
            default: begin wr_addr = UNLK1_ADDR; wr_data = CMD_RESET; end
        endcase
    end
endmodule

// File: rtl/fp_poll_eval.sv
module fp_poll_eval (
    input  logic [7:0] prev_rd,
    input  logic [7:0] cur_rd,
    input  logic [7:0] want,
    output logic       toggled,
    output logic       settled_ok,
    output logic       over_limit
);
    always_comb begin
        toggled    = prev_rd[6] ^ cur_rd[6];
        settled_ok = !toggled && (cur_rd[7:6] == want[7:6]);
        over_limit = toggled && cur_rd[5];
    end
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
    import flash_prog_pkg::*;
#(
    parameter int AW         = 16,
    parameter int WE_CYC     = 3,
    parameter int RD_CYC     = 2,
    parameter int POLL_LIMIT = 4096,
    parameter logic [AW-1:0] UNLK1_ADDR = 'h555,
    parameter logic [AW-1:0] UNLK2_ADDR = 'h2AA
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_data,
    output logic          done,
    output logic          error,
    output logic [AW-1:0] fl_addr,
    output logic [7:0]    fl_dq_out,
    output logic          fl_dq_oe,
    input  logic [7:0]    fl_dq_in,
    output logic          fl_ce_n,
    output logic          fl_oe_n,
    output logic          fl_we_n
);
    localparam int CMAX = (WE_CYC + 1 > RD_CYC) ? WE_CYC + 1 : RD_CYC;
    localparam int CW   = $clog2(CMAX + 1);
    localparam int PCW  = $clog2(POLL_LIMIT + 1);
    localparam logic [CW-1:0]  WE_FIRST = CW'(1);
    localparam logic [CW-1:0]  WE_LOW   = CW'(WE_CYC);
    localparam logic [CW-1:0]  WE_LAST  = CW'(WE_CYC + 1);
    localparam logic [CW-1:0]  RD_LAST  = CW'(RD_CYC - 1);
    localparam logic [PCW-1:0] P_LIMIT  = PCW'(POLL_LIMIT);

    typedef struct packed {
        phase_e        phase;
        next_e         nxt;
        logic [2:0]    step;
        logic [CW-1:0] cnt;
        logic [PCW-1:0] pcnt;
        logic          polling;
        logic          have_prev;
        logic [7:0]    prev;
        logic [1:0]    confirm;
        logic          ext6;
        logic          fail;
        logic [AW-1:0] addr;
        logic [7:0]    data;
        logic          done;
        logic          error;
    } state_t;

    state_t st_q, st_d;

    logic [AW-1:0] cmd_addr_w;
    logic [7:0]    cmd_data_w;
    logic          tog_w, ok_w, lim_w;
    logic          wd_w;

    fp_cmd_sel #(
        .AW(AW), .UNLK1_ADDR(UNLK1_ADDR), .UNLK2_ADDR(UNLK2_ADDR)
    ) u_cmd (
        .step(st_q.step), .tgt_addr(st_q.addr), .tgt_data(st_q.data),
        .wr_addr(cmd_addr_w), .wr_data(cmd_data_w)
    );

    fp_poll_eval u_eval (
        .prev_rd(st_q.prev), .cur_rd(fl_dq_in), .want(st_q.data),
        .toggled(tog_w), .settled_ok(ok_w), .over_limit(lim_w)
    );

    assign wd_w = (st_q.pcnt == P_LIMIT);

    always_comb begin
        st_d       = st_q;
        st_d.done  = 1'b0;
        st_d.error = 1'b0;
        if (st_q.polling && !wd_w) st_d.pcnt = st_q.pcnt + 1'b1;

        case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.addr    = req_addr;
                    st_d.data    = req_data;
                    st_d.step    = 3'd0;
                    st_d.cnt     = '0;
                    st_d.fail    = 1'b0;
                    st_d.polling = 1'b0;
                    st_d.phase   = PH_WR;
                end
            end
            PH_WR: begin
                if (st_q.cnt == WE_LAST) begin
                    st_d.cnt   = '0;
                    st_d.phase = PH_GAP;
                    if (st_q.step == STEP_RESET) begin
                        st_d.nxt = NX_END;
                    end else if (st_q.step == STEP_DATA) begin
                        st_d.nxt       = NX_RD;
                        st_d.polling   = 1'b1;
                        st_d.pcnt      = '0;
                        st_d.have_prev = 1'b0;
                        st_d.confirm   = 2'd0;
                    end else begin
                        st_d.step = st_q.step + 3'd1;
                        st_d.nxt  = NX_WR;
                    end
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_RD: begin
                if (st_q.cnt == RD_LAST) begin
                    st_d.cnt   = '0;
                    st_d.phase = PH_GAP;
                    st_d.nxt   = NX_RD;
                    if (st_q.confirm == 2'd1) begin
                        st_d.ext6    = fl_dq_in[6];
                        st_d.confirm = 2'd2;
                    end else if (st_q.confirm == 2'd2) begin
                        st_d.polling = 1'b0;
                        if (st_q.ext6 != fl_dq_in[6]) begin
                            st_d.fail = 1'b1;
                            st_d.step = STEP_RESET;
                            st_d.nxt  = NX_WR;
                        end else begin
                            st_d.nxt = NX_END;
                        end
                    end else if (wd_w) begin
                        st_d.polling = 1'b0;
                        st_d.fail    = 1'b1;
                        st_d.step    = STEP_RESET;
                        st_d.nxt     = NX_WR;
                    end else if (!st_q.have_prev) begin
                        st_d.prev      = fl_dq_in;
                        st_d.have_prev = 1'b1;
                    end else if (ok_w) begin
                        st_d.polling = 1'b0;
                        st_d.nxt     = NX_END;
                    end else if (lim_w) begin
                        st_d.confirm = 2'd1;
                    end else begin
                        st_d.prev = fl_dq_in;
                    end
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_GAP: begin
                st_d.cnt = '0;
                case (st_q.nxt)
                    NX_WR: st_d.phase = PH_WR;
                    NX_RD: st_d.phase = PH_RD;
                    default: begin
                        st_d.phase = PH_IDLE;
                        st_d.done  = !st_q.fail;
                        st_d.error = st_q.fail;
                    end
                endcase
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done      = st_q.done;
    assign error     = st_q.error;
    assign fl_ce_n   = !((st_q.phase == PH_WR) || (st_q.phase == PH_RD));
    assign fl_oe_n   = !(st_q.phase == PH_RD);
    assign fl_we_n   = !((st_q.phase == PH_WR) && (st_q.cnt >= WE_FIRST) &&
                         (st_q.cnt <= WE_LOW));
    assign fl_dq_oe  = (st_q.phase == PH_WR);
    assign fl_addr   = (st_q.phase == PH_WR) ? cmd_addr_w :
                       (st_q.phase == PH_RD) ? st_q.addr : '0;
    assign fl_dq_out = (st_q.phase == PH_WR) ? cmd_data_w : 8'h00;

endmodule

// File: rtl/fp_prog_chk.sv
module fp_prog_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done,
    input logic          error,
    input logic [AW-1:0] fl_addr,
    input logic [7:0]    fl_dq_out,
    input logic          fl_dq_oe,
    input logic          fl_ce_n,
    input logic          fl_oe_n,
    input logic          fl_we_n
);
    // R3
    no_oe_we_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_oe_n && !fl_we_n));

    // R3
    read_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_oe_n) |-> $past(fl_ce_n));

    // R3
    no_drive_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_oe_n |-> !fl_dq_oe);

    // R2
    bus_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out)));

    // R2
    write_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_we_n) |-> (fl_dq_oe && !fl_ce_n && $past(!fl_ce_n)));

    // R9
    result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    error_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> !error);
endmodule

bind flash_prog_ctrl fp_prog_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_flash_prog_ctrl.sv
module tb_flash_prog_ctrl;
    localparam int AW = 16;
    localparam int M_NORM = 0, M_TMO = 1, M_LATE = 2, M_STUCK = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = '0;
    logic          done, error;
    logic [AW-1:0] fl_addr;
    logic [7:0]    fl_dq_out, fl_dq_in;
    logic          fl_dq_oe, fl_ce_n, fl_oe_n, fl_we_n;

    always #10 clk = ~clk;

    flash_prog_ctrl #(.AW(AW), .WE_CYC(3), .RD_CYC(2), .POLL_LIMIT(120)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .req_addr(req_addr),
        .req_data(req_data), .done(done), .error(error), .fl_addr(fl_addr),
        .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in),
        .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
    );

    int n_chk = 0;
    int n_bad = 0;

    logic [23:0] wq[$];
    bit          rq[$];
    string       tq[$];

    // flash model
    int       m_mode = M_NORM;
    int       m_k = 1;
    int       m_seq = 0;
    int       m_reads = 0;
    bit       m_busy = 0, m_tog = 0, m_b5 = 0;
    logic [7:0] m_data = 8'h00;
    logic [7:0] rd_val;

    assign rd_val   = m_busy ? {~m_data[7], m_tog, m_b5, 5'b0} : m_data;
    assign fl_dq_in = !fl_oe_n ? rd_val : 8'hFF;

    always @(posedge fl_we_n) if (rst_n) begin
        if (fl_dq_out == 8'hF0) begin
            m_busy = 0; m_seq = 0; m_b5 = 0;
        end else if (!m_busy) begin
            case (m_seq)
                0: m_seq = (fl_addr == 16'h0555 && fl_dq_out == 8'hAA) ? 1 : 0;
                1: m_seq = (fl_addr == 16'h02AA && fl_dq_out == 8'h55) ? 2 : 0;
                2: m_seq = (fl_addr == 16'h0555 && fl_dq_out == 8'hA0) ? 3 : 0;
                default: begin
                    m_data = fl_dq_out; m_busy = 1; m_tog = 0; m_b5 = 0;
                    m_reads = 0; m_seq = 0;
                end
            endcase
        end
    end

    always @(posedge fl_oe_n) if (rst_n && m_busy) begin
        m_reads++;
        m_tog = ~m_tog;
        if (m_mode != M_NORM && m_mode != M_STUCK && m_reads == m_k - 1) m_b5 = 1;
        if ((m_mode == M_NORM || m_mode == M_LATE) && m_reads >= m_k) m_busy = 0;
    end

    task automatic fail_line(input string tag, input string what,
                             input logic [31:0] act, input logic [31:0] exp);
        n_bad++;
        $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    endtask

    // write scoreboard monitor (R1, R2, R10)
    logic [AW-1:0] fall_addr;
    logic [7:0]    fall_data;
    always @(negedge fl_we_n) if (rst_n) begin
        fall_addr = fl_addr; fall_data = fl_dq_out;
    end
    always @(posedge fl_we_n) if (rst_n) begin
        logic [23:0] got, exp;
        got = {fl_addr, fl_dq_out};
        n_chk++;
        if ({fall_addr, fall_data} != got) fail_line("R2", "bus moved in strobe", got, {fall_addr, fall_data});
        n_chk++;
        if (wq.size() == 0) fail_line("R10", "unexpected write", got, 24'h0);
        else begin
            exp = wq.pop_front();
            if (got != exp) fail_line("R1", "write order", got, exp);
        end
    end

    // result monitor (R4, R6, R7, R8, R9)
    bit last_pulse = 0;
    int overlap = 0;
    always @(negedge clk) if (rst_n) begin
        if (!fl_oe_n && !fl_we_n) overlap++;
        if (done || error) begin
            n_chk++;
            if (last_pulse) fail_line("R9", "pulse longer than one cycle", {done, error}, 2'b00);
            else if (done && error) fail_line("R9", "done with error", 2'b11, 2'b01);
            else if (rq.size() == 0) fail_line("R10", "unexpected result", {done, error}, 2'b00);
            else begin
                bit e;
                string t;
                e = rq.pop_front();
                t = tq.pop_front();
                if (error != e) fail_line(t, "outcome (error bit)", error, e);
                n_chk++;
                if (wq.size() != 0) fail_line(t, "writes missing at result", wq.size(), 0);
            end
        end
        last_pulse = done || error;
    end

    task automatic run_op(input logic [15:0] a, input logic [7:0] d, input int mode,
                          input int k, input bit exp_err, input string tag, input bit poke);
        m_mode = mode; m_k = k;
        wq.push_back({16'h0555, 8'hAA});
        wq.push_back({16'h02AA, 8'h55});
        wq.push_back({16'h0555, 8'hA0});
        wq.push_back({a, d});
        if (exp_err) wq.push_back({16'h0555, 8'hF0});
        rq.push_back(exp_err);
        tq.push_back(tag);
        @(negedge clk); req_addr = a; req_data = d; start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (poke) begin
            repeat (12) @(negedge clk);
            req_addr = ~a; req_data = ~d; start = 1'b1;   // R10: must be ignored
            @(negedge clk); start = 1'b0;
        end
        for (int i = 0; i < 20000 && rq.size() != 0; i++) @(negedge clk);
        n_chk++;
        if (rq.size() != 0) begin
            fail_line(tag, "no result", 0, 1);
            rq.delete(); tq.delete(); wq.delete();
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        n_chk++;
        fail_line("WD", "run did not finish", 0, 1);
        summary();
    end

    initial begin
        repeat (2) @(negedge clk);
        // R11 reset state
        n_chk++;
        if ({fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe, done, error} != 6'b111000)
            fail_line("R11", "reset outputs", {fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe, done, error}, 6'b111000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R4 R5: plain completion after several toggling reads
        run_op(16'h1234, 8'h5A, M_NORM, 5, 1'b0, "R4", 1'b0);
        n_chk++;
        if (m_reads < 5) fail_line("R5", "stopped polling while toggling", m_reads, 5);
        run_op(16'h0F00, 8'hC3, M_NORM, 1, 1'b0, "R4", 1'b0);
        // R6: limit bit with toggle persisting
        run_op(16'h2001, 8'h81, M_TMO, 4, 1'b1, "R6", 1'b0);
        // R7: limit bit seen, then settled
        run_op(16'h3003, 8'h3C, M_LATE, 3, 1'b0, "R7", 1'b0);
        // R8: never settles, only the watchdog ends it
        run_op(16'h4444, 8'h77, M_STUCK, 1, 1'b1, "R8", 1'b0);
        // R10: start while busy
        run_op(16'hABCD, 8'h00, M_NORM, 8, 1'b0, "R4", 1'b1);

        // R10: nothing starts afterwards
        begin
            int act = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (!fl_ce_n) act++;
            end
            n_chk++;
            if (act != 0) fail_line("R10", "bus active after ignored start", act, 0);
        end
        // R3
        n_chk++;
        if (overlap != 0) fail_line("R3", "oe/we overlap cycles", overlap, 0);
        summary();
    end
endmodule